// File: doc/BRIEF.md
# Coarse-Grained Accelerator Instruction Sequencer

The sequencer sits in front of a matrix accelerator and accepts one wide 96-bit instruction per cycle from an in-order stream. It decodes the instruction, decides whether the instruction may leave, and dispatches it as a one-cycle request to one of four execution units: host transfer, weight fetch, matrix multiply and activation. Each request carries the decoded buffer address, accumulator address and length. The sequencer holds no instruction storage. The stream's valid/ready handshake stalls the producer while the head instruction is blocked.

The host-transfer, matrix and activation units each own a station. A station stays occupied from dispatch until the unit returns a done pulse, which may come thousands of cycles later. Weight reads work differently. They retire as soon as their address has been sent, and an outstanding-fetch counter records the weight data still owed. A matrix multiply waits for both its weights and its inputs. The program orders a layer's activation against the next layer's multiply with explicit synchronization instructions. Configuration, interrupt, debug-tag, nop and halt instructions complete inside the sequencer.

Top module: `cisc_seq`

## Requirements
- R1: The instruction word is split into fields as follows: bits [23:0] are the buffer address, [39:24] the accumulator address, [71:40] the length, [79:72] the opcode and [95:80] the flags. A dispatched unit instruction presents its buffer address, accumulator address and length on the command outputs in the cycle after acceptance.
- R2: Opcodes 1 (host read) and 2 (host write) pulse `host_req_o` for one cycle, with `host_wr_o` low for a read and high for a write. Opcode 3 pulses `wt_req_o`, opcode 4 pulses `mm_req_o` and opcode 5 pulses `act_req_o`. The pulse comes in the cycle after acceptance, and at most one request is high in any cycle.
- R3: After a host, matrix or activation dispatch, the next instruction for the same station is held off with `instr_ready_o` low. It is accepted no earlier than the cycle after that unit's done pulse.
- R4: A weight read (opcode 3) is accepted without waiting for its data. Up to WT_MAX_OUT reads (default 4) may be outstanding. A further weight read stalls until a `wt_fill_i` pulse arrives.
- R5: A matrix multiply stalls while any weight fetch is outstanding or while the host-transfer station is busy.
- R6: Opcode 6 stalls until the activation station is free. Opcode 7 stalls until all stations are free and no weight fetch is outstanding. Without such a sync, a matrix multiply does not wait for a busy activation station.
- R7: Opcode 8 loads the flags into `cfg_o`. Opcode 9 gives a one-cycle `irq_o` pulse. Opcode 10 loads the flags into `tag_o`. Opcode 0 changes nothing.
- R8: Halt (opcode 11) is accepted only when all stations are free and no weight fetch is outstanding. After acceptance `halted_o` is set and `instr_ready_o` stays low until reset.
- R9: Any opcode from 12 to 255 sets a sticky `err_o`, dispatches nothing and otherwise acts as a nop.
- R10: After reset, every request, `irq_o`, `err_o` and `halted_o` is low, and `cfg_o` and `tag_o` are zero.
- R11: A weight fill and a new weight read in the same cycle leave the outstanding count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | Instruction present |
| instr_i | input | 96 | Instruction word |
| instr_ready_o | output | 1 | Instruction accepted this cycle if valid |
| host_req_o | output | 1 | Host-transfer dispatch pulse |
| host_wr_o | output | 1 | Host transfer direction, 1 = write to host |
| host_done_i | input | 1 | Host-transfer completion pulse |
| wt_req_o | output | 1 | Weight-fetch address pulse |
| wt_fill_i | input | 1 | One weight fetch has delivered its data |
| mm_req_o | output | 1 | Matrix-multiply dispatch pulse |
| mm_done_i | input | 1 | Matrix-multiply completion pulse |
| act_req_o | output | 1 | Activation dispatch pulse |
| act_done_i | input | 1 | Activation completion pulse |
| cmd_buf_o | output | 24 | Buffer address of last dispatch |
| cmd_acc_o | output | 16 | Accumulator address of last dispatch |
| cmd_len_o | output | 32 | Length of last dispatch |
| cfg_o | output | 16 | Configuration word |
| tag_o | output | 16 | Last debug tag |
| irq_o | output | 1 | Host interrupt pulse |
| err_o | output | 1 | Sticky undefined-opcode flag |
| halted_o | output | 1 | Sequencer has halted |

## Verification
Two events can land on the outstanding-fetch counter in one cycle: a weight fill can arrive in the same cycle that a new weight read is accepted. The bench provokes this with one fetch already outstanding, driving `wt_fill_i` high while a weight read is at the head of the stream. It judges the result through the matrix stall. A following multiply must stay blocked, and it must be accepted right after exactly one more fill. A second collision, a done pulse arriving while the next instruction for the same station waits, is judged by sampling `instr_ready_o` in the done cycle and in the cycle after it.

// File: rtl/cisc_seq_pkg.sv
package cisc_seq_pkg;
  localparam int BUF_W   = 24;
  localparam int ACC_W   = 16;
  localparam int LEN_W   = 32;
  localparam int OP_W    = 8;
  localparam int FLAG_W  = 16;
  localparam int INSTR_W = BUF_W + ACC_W + LEN_W + OP_W + FLAG_W;

  // held stations: occupied until the unit returns done
  localparam int ST_HOST = 0;
  localparam int ST_MM   = 1;
  localparam int ST_ACT  = 2;
  localparam int N_HELD  = 3;

  localparam logic [OP_W-1:0] OP_NOP      = 8'd0;
  localparam logic [OP_W-1:0] OP_HOST_RD  = 8'd1;
  localparam logic [OP_W-1:0] OP_HOST_WR  = 8'd2;
  localparam logic [OP_W-1:0] OP_WT_RD    = 8'd3;
  localparam logic [OP_W-1:0] OP_MATMUL   = 8'd4;
  localparam logic [OP_W-1:0] OP_ACT      = 8'd5;
  localparam logic [OP_W-1:0] OP_SYNC_ACT = 8'd6;
  localparam logic [OP_W-1:0] OP_SYNC_ALL = 8'd7;
  localparam logic [OP_W-1:0] OP_SET_CFG  = 8'd8;
  localparam logic [OP_W-1:0] OP_IRQ      = 8'd9;
  localparam logic [OP_W-1:0] OP_DBG_TAG  = 8'd10;
  localparam logic [OP_W-1:0] OP_HALT     = 8'd11;

  typedef struct packed {
    logic [FLAG_W-1:0] flags;
    logic [OP_W-1:0]   op;
    logic [LEN_W-1:0]  len;
    logic [ACC_W-1:0]  acc;
    logic [BUF_W-1:0]  buf_a;
  } instr_t;

  typedef struct packed {
    logic [N_HELD-1:0] held;
    logic wt;
    logic mm;
    logic host_wr;
    logic syn_act;
    logic syn_all;
    logic halt;
    logic cfg;
    logic irq;
    logic tag;
    logic bad;
  } dec_t;
endpackage

// File: rtl/cisc_decode.sv
module cisc_decode
  import cisc_seq_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output dec_t            dec_o
);
  always_comb begin
    dec_o = '0;
    unique case (op_i)
      OP_NOP:      ;
      OP_HOST_RD:  dec_o.held[ST_HOST] = 1'b1;
      OP_HOST_WR:  begin dec_o.held[ST_HOST] = 1'b1; dec_o.host_wr = 1'b1; end
      OP_WT_RD:    dec_o.wt = 1'b1;
      OP_MATMUL:   begin dec_o.held[ST_MM] = 1'b1; dec_o.mm = 1'b1; end
      OP_ACT:      dec_o.held[ST_ACT] = 1'b1;
      OP_SYNC_ACT: dec_o.syn_act = 1'b1;
      OP_SYNC_ALL: dec_o.syn_all = 1'b1;
      OP_SET_CFG:  dec_o.cfg = 1'b1;
      OP_IRQ:      dec_o.irq = 1'b1;
      OP_DBG_TAG:  dec_o.tag = 1'b1;
      OP_HALT:     dec_o.halt = 1'b1;
      default:     dec_o.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/cisc_station.sv
module cisc_station (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic done_i,
  output logic busy_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_q <= 1'b0;
    else if (take_i) busy_q <= 1'b1;
    else if (done_i) busy_q <= 1'b0;
  end

  assign busy_o = busy_q;

  // R3
  no_double_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> !busy_q);
  // R3
  done_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> busy_q);
  // R3
  busy_from_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(take_i));
endmodule

// File: rtl/cisc_wt_track.sv
module cisc_wt_track #(
  parameter int MAX_OUT = 4,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic fill_i,
  output logic full_o,
  output logic empty_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (issue_i && !fill_i) cnt_q <= cnt_q + 1'b1;
    else if (fill_i && !issue_i) cnt_q <= cnt_q - 1'b1;
  end

  assign full_o  = (cnt_q == CNT_W'(MAX_OUT));
  assign empty_o = (cnt_q == '0);

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !fill_i) |-> !full_o);
  // R4
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |-> !empty_o);
  // R11
  both_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && fill_i) |=> $stable(cnt_q));
endmodule

// File: rtl/cisc_seq.sv
module cisc_seq
  import cisc_seq_pkg::*;
#(
  parameter int WT_MAX_OUT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               instr_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               instr_ready_o,
  output logic               host_req_o,
  output logic               host_wr_o,
  input  logic               host_done_i,
  output logic               wt_req_o,
  input  logic               wt_fill_i,
  output logic               mm_req_o,
  input  logic               mm_done_i,
  output logic               act_req_o,
  input  logic               act_done_i,
  output logic [BUF_W-1:0]   cmd_buf_o,
  output logic [ACC_W-1:0]   cmd_acc_o,
  output logic [LEN_W-1:0]   cmd_len_o,
  output logic [FLAG_W-1:0]  cfg_o,
  output logic [FLAG_W-1:0]  tag_o,
  output logic               irq_o,
  output logic               err_o,
  output logic               halted_o
);
  instr_t            ins;
  dec_t              dec;
  logic [N_HELD-1:0] busy, take, done_vec;
  logic              wt_full, wt_empty, can_go, accept, wt_issue;
  logic [N_HELD-1:0] req_q;
  logic              wt_req_q, host_wr_q, irq_q, err_q, halted_q;
  logic [BUF_W-1:0]  buf_q;
  logic [ACC_W-1:0]  acc_q;
  logic [LEN_W-1:0]  len_q;
  logic [FLAG_W-1:0] cfg_q, tag_q;

  assign ins = instr_t'(instr_i);

  cisc_decode u_dec (.op_i(ins.op), .dec_o(dec));

  assign done_vec[ST_HOST] = host_done_i;
  assign done_vec[ST_MM]   = mm_done_i;
  assign done_vec[ST_ACT]  = act_done_i;

  for (genvar s = 0; s < N_HELD; s++) begin : g_st
    cisc_station u_st (
      .clk_i, .rst_ni,
      .take_i(take[s]), .done_i(done_vec[s]), .busy_o(busy[s])
    );
  end

  cisc_wt_track #(.MAX_OUT(WT_MAX_OUT)) u_wt (
    .clk_i, .rst_ni,
    .issue_i(wt_issue), .fill_i(wt_fill_i),
    .full_o(wt_full), .empty_o(wt_empty)
  );

  // head-of-stream issue gate
  always_comb begin
    can_go = ~|(dec.held & busy);
    if (dec.wt && wt_full)                             can_go = 1'b0;
    if (dec.mm && (!wt_empty || busy[ST_HOST]))        can_go = 1'b0;
    if (dec.syn_act && busy[ST_ACT])                   can_go = 1'b0;
    if ((dec.syn_all || dec.halt) && (|busy || !wt_empty)) can_go = 1'b0;
  end

  assign instr_ready_o = !halted_q && can_go;
  assign accept        = instr_valid_i && instr_ready_o;
  assign take          = accept ? dec.held : '0;
  assign wt_issue      = accept && dec.wt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q     <= '0;
      wt_req_q  <= 1'b0;
      host_wr_q <= 1'b0;
      irq_q     <= 1'b0;
      err_q     <= 1'b0;
      halted_q  <= 1'b0;
      buf_q     <= '0;
      acc_q     <= '0;
      len_q     <= '0;
      cfg_q     <= '0;
      tag_q     <= '0;
    end else begin
      req_q    <= take;
      wt_req_q <= wt_issue;
      irq_q    <= accept && dec.irq;
      if (accept && (|dec.held || dec.wt)) begin
        buf_q     <= ins.buf_a;
        acc_q     <= ins.acc;
        len_q     <= ins.len;
        host_wr_q <= dec.host_wr;
      end
      if (accept && dec.cfg)  cfg_q    <= ins.flags;
      if (accept && dec.tag)  tag_q    <= ins.flags;
      if (accept && dec.bad)  err_q    <= 1'b1;
      if (accept && dec.halt) halted_q <= 1'b1;
    end
  end

  assign host_req_o = req_q[ST_HOST];
  assign mm_req_o   = req_q[ST_MM];
  assign act_req_o  = req_q[ST_ACT];
  assign wt_req_o   = wt_req_q;
  assign host_wr_o  = host_wr_q;
  assign cmd_buf_o  = buf_q;
  assign cmd_acc_o  = acc_q;
  assign cmd_len_o  = len_q;
  assign cfg_o      = cfg_q;
  assign tag_o      = tag_q;
  assign irq_o      = irq_q;
  assign err_o      = err_q;
  assign halted_o   = halted_q;

  // R2
  one_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({host_req_o, wt_req_o, mm_req_o, act_req_o}));
  // R5
  mm_deps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mm_req_o |-> (wt_empty && !busy[ST_HOST]));
  // R8
  halt_stuck_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);
  // R8
  halt_no_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !instr_ready_o);
  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

// File: tb/sim_cisc_seq.sv
module sim_cisc_seq;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [95:0] instr = '0;
  logic        ready;
  logic        host_req, host_wr, wt_req, mm_req, act_req;
  logic        host_done = 1'b0, wt_fill = 1'b0, mm_done = 1'b0, act_done = 1'b0;
  logic [23:0] cbuf;
  logic [15:0] cacc;
  logic [31:0] clen;
  logic [15:0] cfg, tag;
  logic        irq, err, halted;

  int total = 0;
  int fails = 0;

  always #(PERIOD/2) clk = ~clk;

  cisc_seq u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .instr_valid_i(valid), .instr_i(instr), .instr_ready_o(ready),
    .host_req_o(host_req), .host_wr_o(host_wr), .host_done_i(host_done),
    .wt_req_o(wt_req), .wt_fill_i(wt_fill),
    .mm_req_o(mm_req), .mm_done_i(mm_done),
    .act_req_o(act_req), .act_done_i(act_done),
    .cmd_buf_o(cbuf), .cmd_acc_o(cacc), .cmd_len_o(clen),
    .cfg_o(cfg), .tag_o(tag), .irq_o(irq), .err_o(err), .halted_o(halted)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] b;
    logic [15:0] a;
    logic [31:0] l;
    logic [3:0]  mask;  // {act, mm, wt, host}
    logic        wr;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{8'd1,  24'h0A1B2C, 16'h1111, 32'h0000_0100, 4'b0001, 1'b0},
    '{8'd2,  24'hFFFFFF, 16'hFFFF, 32'hFFFF_FFFF, 4'b0001, 1'b1},
    '{8'd3,  24'h000040, 16'h0002, 32'h0000_1000, 4'b0010, 1'b0},
    '{8'd4,  24'h123456, 16'h7654, 32'h0001_0000, 4'b0100, 1'b0},
    '{8'd5,  24'h800001, 16'h8001, 32'h8000_0001, 4'b1000, 1'b0},
    '{8'd0,  24'h000000, 16'h0000, 32'h0000_0000, 4'b0000, 1'b0},
    '{8'd10, 24'h000000, 16'h0000, 32'h0000_0000, 4'b0000, 1'b0}
  };

  function automatic logic [95:0] mk(logic [7:0] op, logic [23:0] b, logic [15:0] a,
                                     logic [31:0] l, logic [15:0] f);
    return {f, op, l, a, b};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // presents an instruction, waits for acceptance, returns at the negedge after
  task automatic send(logic [95:0] ins, output int waited);
    waited = 0;
    @(negedge clk);
    valid = 1'b1;
    instr = ins;
    #1;
    while (!ready && waited < 1000) begin
      @(negedge clk);
      #1;
      waited++;
    end
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic present(logic [95:0] ins);
    @(negedge clk);
    valid = 1'b1;
    instr = ins;
    #1;
  endtask

  // completes an instruction already presented with ready high
  task automatic finish_present();
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic pulse_host(); @(negedge clk); host_done = 1'b1; @(negedge clk); host_done = 1'b0; #1; endtask
  task automatic pulse_mm();   @(negedge clk); mm_done = 1'b1;   @(negedge clk); mm_done = 1'b0;   #1; endtask
  task automatic pulse_act();  @(negedge clk); act_done = 1'b1;  @(negedge clk); act_done = 1'b0;  #1; endtask
  task automatic pulse_fill(); @(negedge clk); wt_fill = 1'b1;   @(negedge clk); wt_fill = 1'b0;   #1; endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int w;
    int wsum;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 reqs", {host_req, wt_req, mm_req, act_req, irq}, 5'b0);
    chk("R10 flags", {err, halted}, 2'b0);
    chk("R10 cfg/tag", {cfg, tag}, 32'h0);

    // R1 R2 table walk
    foreach (VEC[i]) begin
      send(mk(VEC[i].op, VEC[i].b, VEC[i].a, VEC[i].l, 16'h0), w);
      chk("R2 req mask", {act_req, mm_req, wt_req, host_req}, VEC[i].mask);
      if (VEC[i].mask != 4'b0) begin
        chk("R1 fields", {cbuf, cacc, clen}, {VEC[i].b, VEC[i].a, VEC[i].l});
        if (VEC[i].mask[0]) chk("R2 host dir", host_wr, VEC[i].wr);
      end
      @(negedge clk);
      chk("R2 one-cycle pulse", {act_req, mm_req, wt_req, host_req}, 4'b0);
      if (VEC[i].mask[0]) pulse_host();
      if (VEC[i].mask[1]) pulse_fill();
      if (VEC[i].mask[2]) pulse_mm();
      if (VEC[i].mask[3]) pulse_act();
    end

    // R3 station occupancy
    send(mk(8'd4, 24'h1, 16'h1, 32'h1, 16'h0), w);
    present(mk(8'd4, 24'h2, 16'h2, 32'h2, 16'h0));
    chk("R3 blocked", ready, 1'b0);
    repeat (5) @(negedge clk);
    #1;
    chk("R3 still blocked", ready, 1'b0);
    @(negedge clk);
    mm_done = 1'b1;
    #1;
    chk("R3 blocked in done cycle", ready, 1'b0);
    @(negedge clk);
    mm_done = 1'b0;
    #1;
    chk("R3 free after done", ready, 1'b1);
    finish_present();
    chk("R3 second dispatch", {mm_req, cbuf}, {1'b1, 24'h2});
    pulse_mm();

    // R4 decoupled weight reads
    wsum = 0;
    for (int k = 0; k < 4; k++) begin
      send(mk(8'd3, 24'(k), 16'h0, 32'h10, 16'h0), w);
      wsum += w;
    end
    chk("R4 no wait for data", wsum, 0);
    present(mk(8'd3, 24'h99, 16'h0, 32'h10, 16'h0));
    chk("R4 stall at limit", ready, 1'b0);
    pulse_fill();
    chk("R4 free after fill", ready, 1'b1);
    finish_present();
    repeat (4) pulse_fill();

    // R5 matrix dependencies
    send(mk(8'd3, 24'h5, 16'h0, 32'h10, 16'h0), w);
    present(mk(8'd4, 24'h6, 16'h0, 32'h10, 16'h0));
    chk("R5 wait for weights", ready, 1'b0);
    pulse_fill();
    chk("R5 weights in", ready, 1'b1);
    finish_present();
    pulse_mm();
    send(mk(8'd1, 24'h7, 16'h0, 32'h10, 16'h0), w);
    present(mk(8'd4, 24'h8, 16'h0, 32'h10, 16'h0));
    chk("R5 wait for host", ready, 1'b0);
    pulse_host();
    chk("R5 host done", ready, 1'b1);
    finish_present();
    pulse_mm();

    // R11 fill and issue in one cycle
    send(mk(8'd3, 24'h9, 16'h0, 32'h10, 16'h0), w);
    @(negedge clk);
    valid = 1'b1;
    instr = mk(8'd3, 24'hA, 16'h0, 32'h10, 16'h0);
    wt_fill = 1'b1;
    #1;
    chk("R11 issue with fill", ready, 1'b1);
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    wt_fill = 1'b0;
    present(mk(8'd4, 24'hB, 16'h0, 32'h10, 16'h0));
    chk("R11 one still owed", ready, 1'b0);
    pulse_fill();
    chk("R11 count back to zero", ready, 1'b1);
    finish_present();
    pulse_mm();

    // R6 syncs
    send(mk(8'd5, 24'hC, 16'h0, 32'h10, 16'h0), w);
    send(mk(8'd4, 24'hD, 16'h0, 32'h10, 16'h0), w);
    chk("R6 no implicit wait", w, 0);
    pulse_mm();
    present(mk(8'd6, 24'h0, 16'h0, 32'h0, 16'h0));
    chk("R6 sync waits for act", ready, 1'b0);
    pulse_act();
    chk("R6 sync released", ready, 1'b1);
    finish_present();
    send(mk(8'd1, 24'hE, 16'h0, 32'h10, 16'h0), w);
    send(mk(8'd3, 24'hF, 16'h0, 32'h10, 16'h0), w);
    present(mk(8'd7, 24'h0, 16'h0, 32'h0, 16'h0));
    chk("R6 full sync blocked", ready, 1'b0);
    pulse_host();
    chk("R6 full sync needs weights", ready, 1'b0);
    pulse_fill();
    chk("R6 full sync released", ready, 1'b1);
    finish_present();

    // R7 local instructions
    send(mk(8'd8, 24'h0, 16'h0, 32'h0, 16'hA5C3), w);
    chk("R7 cfg", cfg, 16'hA5C3);
    send(mk(8'd9, 24'h0, 16'h0, 32'h0, 16'h0), w);
    chk("R7 irq pulse", irq, 1'b1);
    @(negedge clk);
    chk("R7 irq drops", irq, 1'b0);
    send(mk(8'd10, 24'h0, 16'h0, 32'h0, 16'h1234), w);
    chk("R7 tag", tag, 16'h1234);
    send(mk(8'd0, 24'h0, 16'h0, 32'h0, 16'hFFFF), w);
    chk("R7 nop no effect", {cfg, tag}, {16'hA5C3, 16'h1234});

    // R9 undefined opcode
    chk("R9 err clear before", err, 1'b0);
    send(mk(8'hC7, 24'h3, 16'h3, 32'h3, 16'hBEEF), w);
    chk("R9 err set", err, 1'b1);
    chk("R9 no dispatch", {act_req, mm_req, wt_req, host_req, irq}, 5'b0);
    chk("R9 state untouched", {cfg, tag}, {16'hA5C3, 16'h1234});

    // R8 halt
    send(mk(8'd5, 24'h1, 16'h0, 32'h10, 16'h0), w);
    present(mk(8'd11, 24'h0, 16'h0, 32'h0, 16'h0));
    chk("R8 halt waits", {ready, halted}, 2'b00);
    pulse_act();
    chk("R8 halt accepted", ready, 1'b1);
    finish_present();
    chk("R8 halted", halted, 1'b1);
    present(mk(8'd0, 24'h0, 16'h0, 32'h0, 16'h0));
    repeat (4) @(negedge clk);
    #1;
    chk("R8 no further fetch", {ready, halted}, 2'b01);
    valid = 1'b0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule